// File: doc/BRIEF.md
# Two-Channel DAC Serial Command Front End

This block is the digital control core of a dual 12-bit voltage-output converter. A host shifts 32-bit command words in over a three-wire serial port: a frame-select line (active low), a serial clock, and a data line. The bits are captured most-significant first on each falling serial-clock edge. The block decodes each completed word into an operation. It keeps, for each channel, an input register (the staged value) and a DAC register (the value driven to the analog stage). The two DAC registers are the block's outputs.

Values move from the input registers to the DAC registers in three ways: the level and falling edge of a load pin, a software command, and a per-channel override mask that makes a channel act as if the load pin were always low. A separate clear pin forces both channels to a programmable preset code. If the clear pin falls while a word is being shifted in, that word is aborted. All serial and pin inputs are synchronised to the system clock, and the serial clock is oversampled.

Top module: `dac2_serial_ctrl`

## Requirements
- R1: A frame is the 32 bits sampled on falling `sclk` edges while `sync_n` is low, first bit = bit 31. Field positions: command = bits 27:24, address = bits 23:20, data = bits 15:4. Address 0000 selects channel A, 0001 selects channel B, 1111 selects both. Command 0000 writes the data field into the input register of each addressed channel.
- R2: A frame in which `sync_n` rises before the 32nd falling `sclk` edge is discarded and changes no register.
- R3: After a command-0000 frame, a channel whose load pin `ldac_n` is low at the 32nd edge copies its input register into its DAC register (synchronous mode). With `ldac_n` high and no override, only the input register changes.
- R4: A falling edge on `ldac_n` copies both input registers into the DAC registers.
- R5: Command 0010 writes the addressed input registers and then copies both input registers into both DAC registers.
- R6: Command 0101 loads the 2-bit clear-code register from frame bits 1:0. The reset value of this register is 00.
- R7: A falling edge on `clr_n` loads both input and DAC registers with the preset chosen by the clear code: 00 gives 0x000, 01 gives 0x800, 10 gives 0xFFF. Code 11 leaves all registers unchanged.
- R8: If `clr_n` falls while `sync_n` is low, the frame in progress is aborted and has no effect.
- R9: Command 0110 loads the override mask: frame bit 0 for channel A, bit 3 for channel B. A channel whose bit is 1 updates on a command-0000 frame regardless of `ldac_n`.
- R10: During and after reset, every register and both outputs are zero, and the mask is clear.
- R11: Command 0001 copies the addressed channel's input register to its DAC register. Command 0011 writes the addressed channel's input register and DAC register together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock, data sampled on its falling edge |
| sync_n | input | 1 | Active-low frame select |
| sdin | input | 1 | Serial data in, MSB first |
| ldac_n | input | 1 | Active-low load pin |
| clr_n | input | 1 | Clear pin, falling-edge triggered |
| dac_a | output | 12 | Channel A DAC register |
| dac_b | output | 12 | Channel B DAC register |

## Verification
The bench first stages values with the load pin high and confirms that the outputs hold, then confirms that they move on the pin's falling edge. A design that updated the outputs on every write would fail this. Each preset code is checked on both outputs, and the load pin is then pulsed again to show that the input registers were also preset. A design that cleared only the DAC registers would bring back the stale staged value at that point.

A frame cut short by `sync_n`, and a frame interrupted by the clear pin, must both leave the registers as they were, apart from the clear itself. A design that decoded a partial or interrupted word would load garbage. The override mask is exercised per channel with the load pin high: a mask bit mapped to the wrong channel would update the wrong output.

// File: rtl/dac2_pkg.sv
package dac2_pkg;

  localparam logic [3:0] CMD_WR_IN   = 4'b0000;
  localparam logic [3:0] CMD_UPD     = 4'b0001;
  localparam logic [3:0] CMD_WR_ALL  = 4'b0010;
  localparam logic [3:0] CMD_WR_UPD  = 4'b0011;
  localparam logic [3:0] CMD_CLRCODE = 4'b0101;
  localparam logic [3:0] CMD_MASK    = 4'b0110;

  localparam logic [3:0] ADDR_BOTH   = 4'b1111;

  // Preset for a clear code, left-aligned in 16 bits; callers take the top bits.
  function automatic logic [15:0] clear_value(input logic [1:0] code);
    case (code)
      2'b01:   clear_value = 16'h8000;
      2'b10:   clear_value = 16'hFFFF;
      default: clear_value = 16'h0000;
    endcase
  endfunction

  function automatic logic addr_hits(input logic [3:0] addr, input int ch);
    addr_hits = (addr == ADDR_BOTH) || (addr == 4'(ch));
  endfunction

endpackage

// File: rtl/dac2_sync.sv
module dac2_sync #(
  parameter int          W   = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST;
      q    <= RST;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/dac2_frame_rx.sv
module dac2_frame_rx #(
  parameter int FRAME_BITS = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_s,
  input  logic                  sync_s,
  input  logic                  sdin_s,
  input  logic                  abort_req,
  output logic                  frame_done,
  output logic [FRAME_BITS-1:0] frame_word
);
  localparam int CW = $clog2(FRAME_BITS + 1);

  logic          sclk_q;
  logic [CW-1:0] count;
  logic          aborted;
  logic          sclk_fall;

  assign sclk_fall = sclk_q & ~sclk_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b1;
      count      <= '0;
      aborted    <= 1'b0;
      frame_done <= 1'b0;
      frame_word <= '0;
    end else begin
      sclk_q     <= sclk_s;
      frame_done <= 1'b0;
      if (sync_s) begin
        count   <= '0;
        aborted <= 1'b0;
      end else begin
        if (abort_req) aborted <= 1'b1;
        if (sclk_fall && count < CW'(FRAME_BITS)) begin
          frame_word <= {frame_word[FRAME_BITS-2:0], sdin_s};
          count      <= count + 1'b1;
          if (count == CW'(FRAME_BITS - 1) && !aborted && !abort_req)
            frame_done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/dac2_chan.sv
module dac2_chan #(
  parameter int DAC_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_load,
  input  logic [DAC_W-1:0] clr_val,
  input  logic             wr_in,
  input  logic             upd,
  input  logic [DAC_W-1:0] wdata,
  output logic [DAC_W-1:0] in_q,
  output logic [DAC_W-1:0] dac_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q  <= '0;
      dac_q <= '0;
    end else if (clr_load) begin
      in_q  <= clr_val;
      dac_q <= clr_val;
    end else begin
      if (wr_in) in_q <= wdata;
      if (upd)   dac_q <= wr_in ? wdata : in_q;
    end
  end
endmodule

// File: rtl/dac2_serial_ctrl.sv
module dac2_serial_ctrl #(
  parameter int DAC_W      = 12,
  parameter int FRAME_BITS = 32,
  parameter int DATA_LSB   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             sync_n,
  input  logic             sdin,
  input  logic             ldac_n,
  input  logic             clr_n,
  output logic [DAC_W-1:0] dac_a,
  output logic [DAC_W-1:0] dac_b
);
  import dac2_pkg::*;

  localparam int NCH      = 2;
  localparam int MASK_STEP = 3;

  logic [4:0] pins_s;
  logic sclk_s, sync_s, sdin_s, ldac_s, clr_s;
  logic ldac_q, clr_q;

  dac2_sync #(.W(5), .RST(5'b11101)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({sclk, sync_n, sdin, ldac_n, clr_n}),
    .q(pins_s)
  );
  assign {sclk_s, sync_s, sdin_s, ldac_s, clr_s} = pins_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldac_q <= 1'b1;
      clr_q  <= 1'b1;
    end else begin
      ldac_q <= ldac_s;
      clr_q  <= clr_s;
    end
  end

  // Named events for the checker
  logic clr_fall, clr_evt, ldac_evt, ldac_low;
  assign clr_fall = clr_q & ~clr_s;
  assign ldac_evt = ldac_q & ~ldac_s;
  assign ldac_low = ~ldac_s;

  logic                  frame_done;
  logic [FRAME_BITS-1:0] frame_word;

  dac2_frame_rx #(.FRAME_BITS(FRAME_BITS)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .sync_s(sync_s), .sdin_s(sdin_s),
    .abort_req(clr_fall),
    .frame_done(frame_done), .frame_word(frame_word)
  );

  logic [3:0]       cmd, addr;
  logic [DAC_W-1:0] wdata;
  assign cmd   = frame_word[27:24];
  assign addr  = frame_word[23:20];
  assign wdata = frame_word[DATA_LSB +: DAC_W];

  logic [1:0]     ccode;
  logic [NCH-1:0] mask;
  logic [DAC_W-1:0] clr_val;

  assign clr_evt = clr_fall && (ccode != 2'b11);
  assign clr_val = clear_value(ccode)[15 -: DAC_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ccode <= 2'b00;
      mask  <= '0;
    end else if (frame_done) begin
      if (cmd == CMD_CLRCODE) ccode <= frame_word[1:0];
      if (cmd == CMD_MASK)
        for (int c = 0; c < NCH; c++) mask[c] <= frame_word[c*MASK_STEP];
    end
  end

  logic [DAC_W-1:0] in_r  [NCH];
  logic [DAC_W-1:0] dac_r [NCH];
  logic [NCH-1:0]   wr_in, upd;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hit;
    assign hit = addr_hits(addr, c);
    assign wr_in[c] = frame_done && hit &&
                      (cmd == CMD_WR_IN || cmd == CMD_WR_ALL || cmd == CMD_WR_UPD);
    assign upd[c] = ldac_evt ||
                    (frame_done && ((cmd == CMD_WR_IN && (ldac_low || mask[c])) ||
                                    cmd == CMD_WR_ALL ||
                                    ((cmd == CMD_UPD || cmd == CMD_WR_UPD) && hit)));

    dac2_chan #(.DAC_W(DAC_W)) u_chan (
      .clk(clk), .rst_n(rst_n),
      .clr_load(clr_evt), .clr_val(clr_val),
      .wr_in(wr_in[c]), .upd(upd[c]), .wdata(wdata),
      .in_q(in_r[c]), .dac_q(dac_r[c])
    );
  end

  assign dac_a = dac_r[0];
  assign dac_b = dac_r[1];

  logic [DAC_W-1:0] in_a, in_b;
  assign in_a = in_r[0];
  assign in_b = in_r[1];
endmodule

// File: rtl/dac2_ctrl_chk.sv
module dac2_ctrl_chk #(
  parameter int DAC_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_s,
  input logic             frame_done,
  input logic [3:0]       cmd,
  input logic [3:0]       addr,
  input logic [DAC_W-1:0] wdata,
  input logic             clr_fall,
  input logic             clr_evt,
  input logic             ldac_evt,
  input logic             ldac_low,
  input logic [1:0]       ccode,
  input logic [1:0]       mask,
  input logic [DAC_W-1:0] in_a,
  input logic [DAC_W-1:0] in_b,
  input logic [DAC_W-1:0] dac_a,
  input logic [DAC_W-1:0] dac_b
);
  import dac2_pkg::*;

  logic cut_frame;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cut_frame <= 1'b0;
    else if (sync_s)        cut_frame <= 1'b0;
    else if (clr_fall)      cut_frame <= 1'b1;
  end

  always @(posedge clk)
    if (!rst_n) assert_reset_zero_R10: assert (dac_a == '0 && dac_b == '0 && in_a == '0);

  assert_clear_preset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> (dac_a == clear_value($past(ccode))[15 -: DAC_W]) &&
                (dac_b == clear_value($past(ccode))[15 -: DAC_W]) &&
                (in_a == dac_a) && (in_b == dac_b));

  assert_clear_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_fall && ccode == 2'b11 && !ldac_evt && !frame_done) |=>
      $stable(dac_a) && $stable(dac_b));

  assert_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_frame || (clr_fall && !sync_s)) |-> !frame_done);

  assert_ldac_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ldac_evt && !clr_evt && !frame_done) |=>
      dac_a == $past(in_a) && dac_b == $past(in_b));

  assert_sw_ldac_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && cmd == CMD_WR_ALL) |=> dac_a == in_a && dac_b == in_b);

  assert_sync_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && cmd == CMD_WR_IN && addr == 4'b0000 && (ldac_low || mask[0])) |=>
      dac_a == $past(wdata));

  assert_async_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && cmd == CMD_WR_IN && !ldac_low && mask == 2'b00 && !ldac_evt) |=>
      $stable(dac_a) && $stable(dac_b));
endmodule

bind dac2_serial_ctrl dac2_ctrl_chk #(.DAC_W(DAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_s(sync_s), .frame_done(frame_done),
  .cmd(cmd), .addr(addr), .wdata(wdata), .clr_fall(clr_fall), .clr_evt(clr_evt),
  .ldac_evt(ldac_evt), .ldac_low(ldac_low), .ccode(ccode), .mask(mask),
  .in_a(in_a), .in_b(in_b), .dac_a(dac_a), .dac_b(dac_b)
);

// File: tb/tb_dac2_serial_ctrl.sv
module tb_dac2_serial_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1, sync_n = 1'b1, sdin = 1'b0, ldac_n = 1'b1, clr_n = 1'b1;
  logic [11:0] dac_a, dac_b;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  dac2_serial_ctrl dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sync_n(sync_n), .sdin(sdin),
    .ldac_n(ldac_n), .clr_n(clr_n), .dac_a(dac_a), .dac_b(dac_b)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%03h expected 0x%03h", req, act, exp);
    end
  endtask

  task automatic send(input logic [3:0] cmd, input logic [3:0] addr,
                      input logic [11:0] data, input logic [3:0] low,
                      input int nbits, input bit clr_mid);
    logic [31:0] w;
    w = {4'h0, cmd, addr, 4'h0, data, low};
    sync_n = 1'b0;
    tick(5);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b1; sdin = w[31-i];
      tick(5);
      sclk = 1'b0;
      tick(5);
      if (clr_mid && i == 10) begin
        clr_n = 1'b0; tick(5); clr_n = 1'b1; tick(5);
      end
    end
    sclk = 1'b1;
    tick(5);
    sync_n = 1'b1;
    tick(10);
  endtask

  task automatic wr(input logic [3:0] cmd, input logic [3:0] addr, input logic [11:0] data);
    send(cmd, addr, data, 4'h0, 32, 1'b0);
  endtask

  task automatic pulse_ldac();
    ldac_n = 1'b0; tick(8); ldac_n = 1'b1; tick(8);
  endtask

  task automatic pulse_clr();
    clr_n = 1'b0; tick(8); clr_n = 1'b1; tick(8);
  endtask

  task automatic t_reset();
    check("R10 reset a", dac_a, 12'h000);
    check("R10 reset b", dac_b, 12'h000);
  endtask

  task automatic t_async();
    ldac_n = 1'b1;
    wr(4'b0000, 4'b0000, 12'h123);
    check("R3 async hold a", dac_a, 12'h000);
    wr(4'b0000, 4'b0001, 12'h456);
    check("R3 async hold b", dac_b, 12'h000);
    pulse_ldac();
    check("R4 ldac edge a", dac_a, 12'h123);
    check("R4 ldac edge b", dac_b, 12'h456);
  endtask

  task automatic t_sync();
    ldac_n = 1'b0; tick(8);
    wr(4'b0000, 4'b0000, 12'h321);
    check("R1 R3 sync write a", dac_a, 12'h321);
    check("R3 sync b", dac_b, 12'h456);
    ldac_n = 1'b1; tick(8);
    check("R3 ldac rise no change", dac_a, 12'h321);
  endtask

  task automatic t_update_cmds();
    wr(4'b0000, 4'b1111, 12'h0AA);
    check("R1 both staged only", dac_a, 12'h321);
    wr(4'b0001, 4'b0000, 12'hFFF);
    check("R11 update a", dac_a, 12'h0AA);
    check("R11 b untouched", dac_b, 12'h456);
    wr(4'b0011, 4'b0001, 12'h777);
    check("R11 write-update b", dac_b, 12'h777);
    check("R11 a untouched", dac_a, 12'h0AA);
  endtask

  task automatic t_sw_ldac();
    wr(4'b0000, 4'b0000, 12'h111);
    check("R3 staged a", dac_a, 12'h0AA);
    wr(4'b0010, 4'b0001, 12'h222);
    check("R5 sw ldac a", dac_a, 12'h111);
    check("R5 sw ldac b", dac_b, 12'h222);
  endtask

  task automatic t_short();
    send(4'b0011, 4'b1111, 12'hABC, 4'h0, 20, 1'b0);
    check("R2 short frame a", dac_a, 12'h111);
    check("R2 short frame b", dac_b, 12'h222);
  endtask

  task automatic t_mask();
    send(4'b0110, 4'h0, 12'h000, 4'b0001, 32, 1'b0);
    wr(4'b0000, 4'b0000, 12'h333);
    check("R9 mask a updates", dac_a, 12'h333);
    wr(4'b0000, 4'b0001, 12'h444);
    check("R9 unmasked b holds", dac_b, 12'h222);
    send(4'b0110, 4'h0, 12'h000, 4'b1000, 32, 1'b0);
    wr(4'b0000, 4'b0001, 12'h555);
    check("R9 mask b updates", dac_b, 12'h555);
    wr(4'b0000, 4'b0000, 12'h666);
    check("R9 unmasked a holds", dac_a, 12'h333);
    send(4'b0110, 4'h0, 12'h000, 4'b0000, 32, 1'b0);
  endtask

  task automatic t_clear();
    pulse_clr();
    check("R6 R7 default zero a", dac_a, 12'h000);
    check("R7 zero b", dac_b, 12'h000);
    send(4'b0101, 4'h0, 12'h000, 4'b0001, 32, 1'b0);
    pulse_clr();
    check("R7 mid a", dac_a, 12'h800);
    check("R7 mid b", dac_b, 12'h800);
    pulse_ldac();
    check("R7 input preset a", dac_a, 12'h800);
    send(4'b0101, 4'h0, 12'h000, 4'b0010, 32, 1'b0);
    pulse_clr();
    check("R7 full a", dac_a, 12'hFFF);
    check("R7 full b", dac_b, 12'hFFF);
    wr(4'b0011, 4'b1111, 12'h5A5);
    send(4'b0101, 4'h0, 12'h000, 4'b0011, 32, 1'b0);
    pulse_clr();
    check("R7 noop a", dac_a, 12'h5A5);
    check("R7 noop b", dac_b, 12'h5A5);
  endtask

  task automatic t_abort();
    send(4'b0101, 4'h0, 12'h000, 4'b0010, 32, 1'b0);
    send(4'b0011, 4'b0000, 12'h999, 4'h0, 32, 1'b1);
    check("R8 abort a", dac_a, 12'hFFF);
    check("R8 abort b", dac_b, 12'hFFF);
    wr(4'b0011, 4'b0000, 12'h999);
    check("R8 next frame ok", dac_a, 12'h999);
  endtask

  initial begin
    tick(4);
    t_reset();
    rst_n = 1'b1;
    tick(6);
    t_reset();
    t_async();
    t_sync();
    t_update_cmds();
    t_sw_ldac();
    t_short();
    t_mask();
    t_clear();
    t_abort();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule